// File: doc/BRIEF.md
# Counter Event Flag Generator

This block turns four kinds of position-counter events into one active-low flag pin, plus a sticky status bit for each event. The events are counter overflow (carry), counter underflow (borrow), the counter reaching the compare value, and the index input being active. A four-bit mask picks which events may pull the flag low. Status bits record every event, whether or not its mask bit is set.

Two output modes share the same event sources. In latched mode the flag stays low while any masked-in status bit is set, so it holds until software clears status. In pulse mode the flag goes low for one clock for each cycle that carries a new masked-in event. A global enable forces the pin high when it is off. The counter arithmetic and the host register access sit outside this block. They supply the strobes and levels, and they issue the clear.

Event bit order in both `evt_stat` and `evt_en`:
- bit 0: carry
- bit 1: borrow
- bit 2: compare
- bit 3: index

Top module: `evt_flag_out`

## Requirements
- R1: While `rst_n` is low, and after its release until the first event, `flag_n` is 1 and `evt_stat` is 0.
- R2: A rising clock edge that samples `ovf_stb` high sets `evt_stat[0]` (carry) at that edge.
- R3: A rising clock edge that samples `unf_stb` high sets `evt_stat[1]` (borrow) at that edge.
- R4: A compare event occurs at an edge where `cnt_val == cmp_val` and the two were unequal at the previous edge. The first edge after reset also counts when they are equal. A compare event sets `evt_stat[2]`. A counter that stays on the compare value gives no further compare events.
- R5: Every edge that samples `idx_act` high sets `evt_stat[3]`. For pulse mode, only an edge where `idx_act` goes from 0 to 1 counts as an index event.
- R6: Status bits stay set until an edge samples `stat_clr` high, which clears them all. An event sampled at the same edge as the clear leaves its bit set.
- R7: In latched mode (`pulse_mode`=0, `flag_en`=1), `flag_n` is 0 after every edge at which some status bit is set whose `evt_en` bit is 1. Otherwise `flag_n` is 1.
- R8: In pulse mode (`pulse_mode`=1, `flag_en`=1), `flag_n` is 0 for exactly the one clock after an edge that carries a masked-in event, and 1 after any edge that carries none.
- R9: An event whose `evt_en` bit is 0 never drives `flag_n` low, but it still sets its status bit.
- R10: After any edge that samples `flag_en` low, `flag_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cmp_val | input | CNT_W | Compare register value |
| ovf_stb | input | 1 | Counter overflow strobe (carry) |
| unf_stb | input | 1 | Counter underflow strobe (borrow) |
| idx_act | input | 1 | Index input at its active level |
| evt_en | input | 4 | Event mask, bit order carry, borrow, compare, index |
| pulse_mode | input | 1 | 1 = one-clock pulse, 0 = latched level |
| flag_en | input | 1 | 0 forces the flag high |
| stat_clr | input | 1 | Clears all status bits |
| flag_n | output | 1 | Active-low flag pin |
| evt_stat | output | 4 | Sticky event status, same bit order as the mask |

## Verification
Directed phases drive each event alone, under both modes and with its mask bit on and then off. This separates the event sources from one another and latched behaviour from pulse behaviour. A counter held on the compare value, and an index held high for several clocks, show that edge detection in pulse mode is independent of the level-set status bits. Clears issued in the same cycle as an event, and disable toggles during activity, exercise how clear and disable take priority. A final phase with random inputs, checked against a behavioural model on every clock, covers combinations the directed phases do not reach.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  localparam int NUM_EV   = 4;
  localparam int EV_CARRY = 0;
  localparam int EV_BORROW = 1;
  localparam int EV_CMP   = 2;
  localparam int EV_INDEX = 3;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/evt_detect.sv
module evt_detect
  import evt_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ovf_stb,
  input  logic             unf_stb,
  input  logic             idx_act,
  output ev_vec_t          ev_lvl,
  output ev_vec_t          ev_edge
);
  logic eq_now, eq_q, eq_d;
  logic idx_q, idx_d;
  logic cmp_rise, idx_rise;

  always_comb begin
    eq_now   = (cnt_val == cmp_val);
    eq_d     = eq_now;
    idx_d    = idx_act;
    cmp_rise = eq_now & ~eq_q;
    idx_rise = idx_act & ~idx_q;
    ev_lvl            = '0;
    ev_lvl[EV_CARRY]  = ovf_stb;
    ev_lvl[EV_BORROW] = unf_stb;
    ev_lvl[EV_CMP]    = cmp_rise;
    ev_lvl[EV_INDEX]  = idx_act;
    ev_edge           = ev_lvl;
    ev_edge[EV_INDEX] = idx_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      eq_q  <= eq_d;
      idx_q <= idx_d;
    end
  end

  // R4: a value resting on the compare register yields no repeat event
  assert_cmp_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_now && eq_q) |-> !ev_lvl[EV_CMP]);
  // R5: index edge only on a low-to-high change
  assert_idx_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_edge[EV_INDEX]) |=> ($past(idx_act) && !$past(idx_q)));
endmodule

// File: rtl/evt_status.sv
module evt_status
  import evt_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev_lvl,
  input  logic    stat_clr,
  output ev_vec_t stat_q,
  output ev_vec_t stat_d
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_comb begin
      stat_d[i] = (stat_q[i] & ~stat_clr) | ev_lvl[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end

    // R6: a set bit survives every edge without a clear
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !stat_clr) |=> stat_q[i]);
    // R6: event in the clear cycle still wins
    assert_clr_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_lvl[i] && stat_clr) |=> stat_q[i]);
  end
endmodule

// File: rtl/evt_flag_drive.sv
module evt_flag_drive
  import evt_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev_edge,
  input  ev_vec_t stat_d,
  input  ev_vec_t evt_en,
  input  logic    pulse_mode,
  input  logic    flag_en,
  output logic    flag_n
);
  logic    flag_d;
  ev_vec_t src;

  always_comb begin
    src    = pulse_mode ? ev_edge : stat_d;
    flag_d = ~(flag_en & |(src & evt_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_n <= 1'b1;
    else        flag_n <= flag_d;
  end

  // R10: disable forces the pin high
  assert_disable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> flag_n);
  // R8: no masked-in edge event in pulse mode leaves the pin high
  assert_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && ((ev_edge & evt_en) == '0)) |=> flag_n);
endmodule

// File: rtl/evt_flag_out.sv
module evt_flag_out
  import evt_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ovf_stb,
  input  logic             unf_stb,
  input  logic             idx_act,
  input  logic [3:0]       evt_en,
  input  logic             pulse_mode,
  input  logic             flag_en,
  input  logic             stat_clr,
  output logic             flag_n,
  output logic [3:0]       evt_stat
);
  ev_vec_t ev_lvl, ev_edge, stat_q, stat_d;

  evt_detect #(.CNT_W(CNT_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .ovf_stb(ovf_stb), .unf_stb(unf_stb), .idx_act(idx_act),
    .ev_lvl(ev_lvl), .ev_edge(ev_edge)
  );

  evt_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_lvl(ev_lvl), .stat_clr(stat_clr),
    .stat_q(stat_q), .stat_d(stat_d)
  );

  evt_flag_drive u_drive (
    .clk(clk), .rst_n(rst_n), .ev_edge(ev_edge), .stat_d(stat_d),
    .evt_en(evt_en), .pulse_mode(pulse_mode), .flag_en(flag_en),
    .flag_n(flag_n)
  );

  assign evt_stat = stat_q;

  // R2: overflow strobe is recorded
  assert_carry_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |=> evt_stat[EV_CARRY]);
  // R3: underflow strobe is recorded
  assert_borrow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unf_stb |=> evt_stat[EV_BORROW]);
  // R7: latched mode holds the pin low while a masked-in bit is set
  assert_latched_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !pulse_mode && !stat_clr && |(evt_stat & evt_en)) |=> !flag_n);
endmodule

// File: tb/tb_evt_flag_out.sv
module tb_evt_flag_out;
  localparam int CNT_W = 16;
  localparam time TCK  = 20ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_val, cmp_val;
  logic             ovf_stb, unf_stb, idx_act, pulse_mode, flag_en, stat_clr;
  logic [3:0]       evt_en;
  logic             flag_n;
  logic [3:0]       evt_stat;

  evt_flag_out #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .ovf_stb(ovf_stb), .unf_stb(unf_stb), .idx_act(idx_act),
    .evt_en(evt_en), .pulse_mode(pulse_mode), .flag_en(flag_en),
    .stat_clr(stat_clr), .flag_n(flag_n), .evt_stat(evt_stat)
  );

  always #(TCK/2) clk = ~clk;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   m_eq_prev  = 0;
  bit   m_idx_prev = 0;
  bit   m_flag     = 1;
  bit [3:0] m_stat = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic compare(string tag);
    n_vec++;
    if (flag_n !== m_flag || evt_stat !== m_stat) begin
      n_bad++;
      $display("FAIL %s: flag_n=%b stat=%b expected flag_n=%b stat=%b",
               tag, flag_n, evt_stat, m_flag, m_stat);
    end
  endtask

  // Advance one clock: update the behavioural model at the edge, compare mid-cycle
  task automatic step(string tag);
    bit eq, cmp_ev, idx_ev;
    bit [3:0] lvl, edg, nstat, pick;
    @(posedge clk);
    eq     = (cnt_val == cmp_val);
    cmp_ev = eq && !m_eq_prev;
    idx_ev = idx_act && !m_idx_prev;
    m_eq_prev  = eq;
    m_idx_prev = idx_act;
    lvl   = {idx_act, cmp_ev, unf_stb, ovf_stb};
    edg   = {idx_ev,  cmp_ev, unf_stb, ovf_stb};
    nstat = (stat_clr ? 4'b0 : m_stat) | lvl;
    pick  = pulse_mode ? edg : nstat;
    m_flag = !(flag_en && ((pick & evt_en) != 0));
    m_stat = nstat;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    ovf_stb = 0; unf_stb = 0; idx_act = 0; stat_clr = 0;
  endtask

  task automatic clear(string tag);
    stat_clr = 1; step(tag); stat_clr = 0;
  endtask

  initial begin
    #(TCK*200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    rst_n = 0; cnt_val = 0; cmp_val = 16'h0100; idle();
    evt_en = 4'hF; pulse_mode = 0; flag_en = 1;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    step("R1 after release");
    step("R1 idle");

    // R2 carry, latched, masked in
    ovf_stb = 1; step("R2 carry set"); ovf_stb = 0;
    step("R7 latched hold");
    step("R7 latched hold");
    clear("R6 clear");
    step("R7 released after clear");

    // R3 borrow
    unf_stb = 1; step("R3 borrow set"); unf_stb = 0;
    step("R7 hold");
    // R6 clear and event in the same cycle
    stat_clr = 1; unf_stb = 1; step("R6 clear race"); idle();
    step("R6 race kept");
    clear("R6 clear");

    // R4 compare: arrive, rest, leave, return
    cnt_val = 16'h00FF; step("R4 unequal");
    cnt_val = 16'h0100; step("R4 match");
    step("R4 resting"); clear("R4 clear while resting");
    step("R4 no repeat"); step("R4 no repeat");
    cnt_val = 16'h0101; step("R4 leave");
    cnt_val = 16'h0100; step("R4 return");
    clear("R6 clear");

    // R5 index level in latched mode
    idx_act = 1; step("R5 index level"); step("R5 index level");
    stat_clr = 1; step("R5 level overrides clear"); idle();
    step("R5 index low"); clear("R6 clear");

    // R9 mask out events
    evt_en = 4'b0000; ovf_stb = 1; unf_stb = 1; idx_act = 1;
    step("R9 masked, status still set"); idle();
    step("R9 masked hold");
    evt_en = 4'b0010; step("R7 mask change exposes borrow");
    clear("R6 clear");
    evt_en = 4'hF;

    // R8 pulse mode
    pulse_mode = 1;
    ovf_stb = 1; step("R8 carry pulse"); ovf_stb = 0;
    step("R8 pulse ends"); step("R8 idle");
    idx_act = 1; step("R8 index rise pulse");
    step("R8 index held no pulse"); step("R8 index held no pulse");
    idx_act = 0; step("R8 index fall");
    cnt_val = 16'h0200; step("R8 leave compare");
    cmp_val = 16'h0200; step("R8 compare pulse");
    step("R8 resting no pulse");
    unf_stb = 1; step("R8 back-to-back"); step("R8 back-to-back"); unf_stb = 0;
    step("R8 idle");
    evt_en = 4'b1110; ovf_stb = 1; step("R9 carry masked pulse"); idle();
    evt_en = 4'hF;
    clear("R6 clear");

    // R10 disable
    flag_en = 0; pulse_mode = 0; ovf_stb = 1;
    step("R10 disabled high"); idle(); step("R10 disabled high");
    flag_en = 1; step("R7 enable shows latched carry");
    flag_en = 0; step("R10 disabled again");
    flag_en = 1; clear("R6 clear");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      ovf_stb    = ($urandom % 8) == 0;
      unf_stb    = ($urandom % 8) == 0;
      idx_act    = ($urandom % 4) == 0 ? ~idx_act : idx_act;
      stat_clr   = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) cnt_val = 16'(($urandom % 4) + 16'h0200);
      if (($urandom % 40) == 0) evt_en = 4'($urandom);
      if (($urandom % 30) == 0) pulse_mode = ~pulse_mode;
      if (($urandom % 50) == 0) flag_en = ~flag_en;
      step("R9 random mix");
    end
    report();
  end
endmodule